// File: doc/BRIEF.md
# Atomic Ordering and Reservation Checker

This block sits between one processor port and its cache controller and rules on every request the port issues. Plain accesses, read-modify-write halves and load-linked/store-conditional pairs are each checked against a small amount of ordering state. In the same cycle the request is presented, the block answers with one of three outcomes: issue it, fail it, or flag it as a sequencing error. Read-modify-write bookkeeping uses a read counter and a write counter that clear on their own once every read has been matched by a write. A half-finished sequence that never began its writes is abandoned cleanly when a plain access arrives. A sequence whose writes have started but not finished is reported as broken.

A single reservation register holds the line and owner ID from the most recent completed load-linked. A store-conditional is issued only when that reservation matches both its line and its owner. Otherwise it returns the failure code -2 and is dropped. Completions reported back by the cache drive set and clear commands for the per-line atomic flag kept by the controller. Any sequencing error also sets a sticky error output.

Top module: `atom_seq_checker`

## Requirements
- R1: Request kinds on `req_kind` are encoded 0 load, 1 store, 2 instruction fetch, 3 RMW read, 4 RMW write, 5 load-linked, 6 store-conditional, 7 none. With no atomic sequence open, a valid plain request raises `issue` in the same cycle. Kind 7 and `req_valid` low raise no output.
- R2: An RMW read is issued and increments the read count only when the write count is zero. Otherwise it raises `seq_error` and is not issued.
- R3: An RMW write is issued and increments the write count only when the read count is above zero and the write count is below it. Otherwise it raises `seq_error` and is not issued.
- R4: When an issued RMW write makes the write count equal to the read count, both counts return to zero.
- R5: A plain request that arrives with reads above zero and writes at zero is issued, pulses `reset_atomics`, and clears both counts.
- R6: A plain request that arrives with the write count above zero raises `seq_error`, is not issued, and leaves both counts unchanged.
- R7: Load-linked and store-conditional requests leave both RMW counts unchanged.
- R8: A load-linked completion (`cmp_kind` 5) records a reservation for `cmp_line` owned by `cmp_owner`. A store-conditional whose line and owner both match it is issued and clears the reservation.
- R9: A store-conditional with no matching reservation raises `sc_fail`, drives `fail_code` to -2 (0 at all other times), and is not issued.
- R10: An issued store to the reserved line, or `inv_valid` with `inv_line` equal to it, clears the reservation. A store to another line does not. A load-linked completion in the same cycle wins over any clear.
- R11: A completion of kind 3 raises `flag_set`, and one of kind 4 raises `flag_clr`, each with `flag_line` equal to `cmp_line`.
- R12: `err_sticky` rises in the cycle after any `seq_error` and stays high until reset. Reset leaves it low.
- R13: An RMW read that arrives when the read count is at its maximum (2^CNT_W-1) raises `seq_error` and is not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Request kind (see R1) |
| req_line | input | LINE_W | Line address of the request |
| req_owner | input | OWNER_W | Requester ID |
| cmp_valid | input | 1 | Completion reported by the cache |
| cmp_kind | input | 3 | Kind of the completed request |
| cmp_line | input | LINE_W | Line of the completed request |
| cmp_owner | input | OWNER_W | Requester ID of the completed request |
| inv_valid | input | 1 | External invalidation of a line |
| inv_line | input | LINE_W | Invalidated line |
| issue | output | 1 | Request may be forwarded |
| sc_fail | output | 1 | Store-conditional refused |
| fail_code | output | 8 | Signed result code: -2 on refusal, else 0 |
| seq_error | output | 1 | Ordering rule broken by this request |
| err_sticky | output | 1 | Some ordering error seen since reset |
| reset_atomics | output | 1 | Abandon open atomic sequence in controller |
| flag_set | output | 1 | Set atomic flag of `flag_line` |
| flag_clr | output | 1 | Clear atomic flag of `flag_line` |
| flag_line | output | LINE_W | Line for flag commands |

## Verification
The bench targets the boundaries of the counter pair. These include a write arriving with no reads, a write count catching up with the read count, a read arriving when the counter is full, and a plain access with writes half-done. A design that got one of these wrong would either let a broken sequence through or refuse a legal one. For the reservation, the bench tries a store-conditional with the wrong owner, with the wrong line, a second time after a success, after a same-line store, after an invalidation, and with a completion racing an invalidation. A design that failed to compare the owner, or failed to consume the reservation, would issue a store it should have refused. The bench also checks that load-linked and store-conditional traffic in the middle of an RMW pair leaves the pair undisturbed.

// File: rtl/atom_pkg.sv
package atom_pkg;

    typedef enum logic [2:0] {
        K_LOAD  = 3'd0,
        K_STORE = 3'd1,
        K_FETCH = 3'd2,
        K_RMW_R = 3'd3,
        K_RMW_W = 3'd4,
        K_LL    = 3'd5,
        K_SC    = 3'd6,
        K_NONE  = 3'd7
    } req_kind_e;

    localparam logic signed [7:0] SC_FAIL_CODE = -8'sd2;

endpackage

// File: rtl/atom_rmw_pair.sv
module atom_rmw_pair
    import atom_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  req_kind_e req_kind,
    output logic      pair_err,
    output logic      rst_atom
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] rd;
        logic [CNT_W-1:0] wr;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic plain;

    always_comb begin
        cnt_d    = cnt_q;
        pair_err = 1'b0;
        rst_atom = 1'b0;
        plain    = req_valid && (req_kind == K_LOAD || req_kind == K_STORE || req_kind == K_FETCH);
        if (plain) begin
            if (cnt_q.wr != '0) begin
                pair_err = 1'b1;
            end else if (cnt_q.rd != '0) begin
                rst_atom = 1'b1;
                cnt_d    = '0;
            end
        end else if (req_valid && req_kind == K_RMW_R) begin
            if (cnt_q.wr != '0 || cnt_q.rd == CNT_MAX) begin
                pair_err = 1'b1;
            end else begin
                cnt_d.rd = cnt_q.rd + 1'b1;
            end
        end else if (req_valid && req_kind == K_RMW_W) begin
            if (cnt_q.rd == '0 || cnt_q.wr >= cnt_q.rd) begin
                pair_err = 1'b1;
            end else if (cnt_q.wr + 1'b1 == cnt_q.rd) begin
                cnt_d = '0;
            end else begin
                cnt_d.wr = cnt_q.wr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // writes never catch up with reads without the pair clearing
    assert_wr_below_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.wr == '0) || (cnt_q.wr < cnt_q.rd));

    assert_abandon_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_atom |=> (cnt_q.rd == '0 && cnt_q.wr == '0));

    assert_broken_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_err && plain) |=> ($stable(cnt_q.rd) && $stable(cnt_q.wr)));

    assert_ll_sc_neutral_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == K_LL || req_kind == K_SC)) |=> $stable(cnt_q));

endmodule

// File: rtl/atom_resv.sv
module atom_resv #(
    parameter int LINE_W  = 32,
    parameter int OWNER_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sc_req,
    input  logic               st_req,
    input  logic [LINE_W-1:0]  req_line,
    input  logic [OWNER_W-1:0] req_owner,
    input  logic               ll_done,
    input  logic [LINE_W-1:0]  cmp_line,
    input  logic [OWNER_W-1:0] cmp_owner,
    input  logic               inv_valid,
    input  logic [LINE_W-1:0]  inv_line,
    output logic               sc_hit
);
    typedef struct packed {
        logic               vld;
        logic [LINE_W-1:0]  line;
        logic [OWNER_W-1:0] owner;
    } resv_t;

    resv_t rs_d, rs_q;
    logic  line_match;

    always_comb begin
        rs_d       = rs_q;
        line_match = rs_q.vld && (rs_q.line == req_line);
        sc_hit     = sc_req && line_match && (rs_q.owner == req_owner);
        if (sc_hit || (st_req && line_match)) rs_d.vld = 1'b0;
        if (inv_valid && rs_q.vld && inv_line == rs_q.line) rs_d.vld = 1'b0;
        if (ll_done) begin
            rs_d.vld   = 1'b1;
            rs_d.line  = cmp_line;
            rs_d.owner = cmp_owner;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assert_sc_consumes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_hit && !ll_done) |=> !sc_hit_possible());

    assert_inval_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && rs_q.vld && inv_line == rs_q.line && !ll_done) |=> !rs_q.vld);

    assert_ll_records_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ll_done |=> (rs_q.vld && rs_q.line == $past(cmp_line) && rs_q.owner == $past(cmp_owner)));

    function automatic logic sc_hit_possible();
        return rs_q.vld;
    endfunction

endmodule

// File: rtl/atom_seq_checker.sv
module atom_seq_checker
    import atom_pkg::*;
#(
    parameter int LINE_W  = 32,
    parameter int OWNER_W = 4,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_kind,
    input  logic [LINE_W-1:0]  req_line,
    input  logic [OWNER_W-1:0] req_owner,
    input  logic               cmp_valid,
    input  logic [2:0]         cmp_kind,
    input  logic [LINE_W-1:0]  cmp_line,
    input  logic [OWNER_W-1:0] cmp_owner,
    input  logic               inv_valid,
    input  logic [LINE_W-1:0]  inv_line,
    output logic               issue,
    output logic               sc_fail,
    output logic [7:0]         fail_code,
    output logic               seq_error,
    output logic               err_sticky,
    output logic               reset_atomics,
    output logic               flag_set,
    output logic               flag_clr,
    output logic [LINE_W-1:0]  flag_line
);
    req_kind_e kind;
    logic      pair_err, sc_hit, sc_req, st_req, ll_done;
    logic      err_d, err_q;

    assign kind    = req_kind_e'(req_kind);
    assign sc_req  = req_valid && kind == K_SC;
    assign st_req  = req_valid && kind == K_STORE && !pair_err;
    assign ll_done = cmp_valid && cmp_kind == 3'(K_LL);

    atom_rmw_pair #(.CNT_W(CNT_W)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (kind),
        .pair_err  (pair_err),
        .rst_atom  (reset_atomics)
    );

    atom_resv #(.LINE_W(LINE_W), .OWNER_W(OWNER_W)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .sc_req    (sc_req),
        .st_req    (st_req),
        .req_line  (req_line),
        .req_owner (req_owner),
        .ll_done   (ll_done),
        .cmp_line  (cmp_line),
        .cmp_owner (cmp_owner),
        .inv_valid (inv_valid),
        .inv_line  (inv_line),
        .sc_hit    (sc_hit)
    );

    always_comb begin
        err_d     = err_q || pair_err;
        seq_error = pair_err;
        sc_fail   = sc_req && !sc_hit;
        fail_code = sc_fail ? SC_FAIL_CODE : 8'sd0;
        issue     = 1'b0;
        if (req_valid && kind != K_NONE) begin
            if (kind == K_SC) issue = sc_hit;
            else              issue = !pair_err;
        end
        flag_set  = cmp_valid && cmp_kind == 3'(K_RMW_R);
        flag_clr  = cmp_valid && cmp_kind == 3'(K_RMW_W);
        flag_line = cmp_line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err_sticky = err_q;

    assert_sticky_rises_R12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_error |=> err_sticky);

    assert_sticky_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    assert_refused_sc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sc_fail |-> (!issue && fail_code == 8'hFE));

    assert_error_not_issued_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_error |-> !issue);

endmodule

// File: tb/sim_atom_seq_checker.sv
module sim_atom_seq_checker;
    localparam int CLK_P = 10;
    localparam int LW = 4;
    localparam int OW = 2;

    localparam logic [2:0] KLD = 3'd0, KST = 3'd1, KIF = 3'd2, KRR = 3'd3,
                           KRW = 3'd4, KLL = 3'd5, KSC = 3'd6, KNO = 3'd7;
    // expected bits: issue, sc_fail, seq_error, reset_atomics, flag_set, flag_clr
    localparam logic [5:0] E0 = 6'b000000, EI = 6'b100000, ES = 6'b010000,
                           EE = 6'b001000, ER = 6'b000100, EFS = 6'b000010,
                           EFC = 6'b000001;

    typedef struct packed {
        logic [2:0]    k;
        logic [LW-1:0] ln;
        logic [OW-1:0] ow;
        logic          cv;
        logic [2:0]    ck;
        logic [LW-1:0] cl;
        logic [OW-1:0] co;
        logic          iv;
        logic [LW-1:0] il;
        logic [5:0]    ex;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VEC [NV] = '{
        '{KNO, 4'd0, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, E0},       // 0  R1 idle
        '{KLD, 4'd1, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 1  R1
        '{KRR, 4'd2, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 2  R2
        '{KRW, 4'd2, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 3  R3 R4
        '{KIF, 4'd3, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 4  R4 no reset
        '{KRR, 4'd2, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 5
        '{KRR, 4'd3, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 6
        '{KRW, 4'd2, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 7
        '{KLD, 4'd1, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EE},       // 8  R6
        '{KRW, 4'd3, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 9  R6 kept, R4
        '{KRW, 4'd3, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EE},       // 10 R3
        '{KRR, 4'd4, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 11
        '{KST, 4'd5, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI | ER},  // 12 R5
        '{KRW, 4'd4, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EE},       // 13 R5 cleared
        '{KRR, 4'd4, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 14
        '{KLL, 4'd6, 2'd1, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 15 R7
        '{KSC, 4'd6, 2'd1, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, ES},       // 16 R9 no resv
        '{KRW, 4'd4, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 17 R7
        '{KNO, 4'd0, 2'd0, 1'b1, KLL, 4'd6, 2'd1, 1'b0, 4'd0, E0},       // 18 R8 set
        '{KSC, 4'd6, 2'd2, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, ES},       // 19 R9 owner
        '{KSC, 4'd7, 2'd1, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, ES},       // 20 R9 line
        '{KSC, 4'd6, 2'd1, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 21 R8
        '{KSC, 4'd6, 2'd1, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, ES},       // 22 R8 consumed
        '{KNO, 4'd0, 2'd0, 1'b1, KLL, 4'd6, 2'd1, 1'b0, 4'd0, E0},       // 23
        '{KST, 4'd6, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 24 R10
        '{KSC, 4'd6, 2'd1, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, ES},       // 25 R10
        '{KNO, 4'd0, 2'd0, 1'b1, KLL, 4'd8, 2'd0, 1'b0, 4'd0, E0},       // 26
        '{KNO, 4'd0, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b1, 4'd8, E0},       // 27 R10 inval
        '{KSC, 4'd8, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, ES},       // 28 R10
        '{KNO, 4'd0, 2'd0, 1'b1, KLL, 4'd9, 2'd0, 1'b1, 4'd9, E0},       // 29 R10 race
        '{KSC, 4'd9, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 30 R10
        '{KNO, 4'd0, 2'd0, 1'b1, KRR, 4'd4, 2'd0, 1'b0, 4'd0, EFS},      // 31 R11
        '{KNO, 4'd0, 2'd0, 1'b1, KRW, 4'd4, 2'd0, 1'b0, 4'd0, EFC},      // 32 R11
        '{KRR, 4'd1, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 33
        '{KRR, 4'd2, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 34
        '{KRR, 4'd3, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 35
        '{KRR, 4'd4, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EE},       // 36 R13 full
        '{KRW, 4'd1, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 37
        '{KRW, 4'd2, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 38
        '{KRW, 4'd3, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 39 R4
        '{KLD, 4'd1, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},       // 40 R4
        '{KNO, 4'd0, 2'd0, 1'b1, KLL, 4'd10, 2'd3, 1'b0, 4'd0, E0},      // 41
        '{KST, 4'd11, 2'd0, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI},      // 42 R10 other line
        '{KSC, 4'd10, 2'd3, 1'b0, KNO, 4'd0, 2'd0, 1'b0, 4'd0, EI}       // 43 R10
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, cmp_valid = 1'b0, inv_valid = 1'b0;
    logic [2:0] req_kind = KNO, cmp_kind = KNO;
    logic [LW-1:0] req_line = '0, cmp_line = '0, inv_line = '0;
    logic [OW-1:0] req_owner = '0, cmp_owner = '0;
    logic issue, sc_fail, seq_error, err_sticky, reset_atomics, flag_set, flag_clr;
    logic [7:0] fail_code;
    logic [LW-1:0] flag_line;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    atom_seq_checker #(.LINE_W(LW), .OWNER_W(OW), .CNT_W(2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line), .req_owner(req_owner),
        .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_line(cmp_line), .cmp_owner(cmp_owner),
        .inv_valid(inv_valid), .inv_line(inv_line),
        .issue(issue), .sc_fail(sc_fail), .fail_code(fail_code), .seq_error(seq_error),
        .err_sticky(err_sticky), .reset_atomics(reset_atomics),
        .flag_set(flag_set), .flag_clr(flag_clr), .flag_line(flag_line)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; req_kind = KNO; cmp_valid = 1'b0; cmp_kind = KNO; inv_valid = 1'b0;
    endtask

    initial begin
        bit seen_err;
        seen_err = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state (R1, R12)
        check("R1 reset issue", 32'(issue), 0);
        check("R12 reset sticky", 32'(err_sticky), 0);
        check("R9 reset fail_code", 32'(fail_code), 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = (VEC[i].k != KNO);
            req_kind  = VEC[i].k;
            req_line  = VEC[i].ln;
            req_owner = VEC[i].ow;
            cmp_valid = VEC[i].cv;
            cmp_kind  = VEC[i].ck;
            cmp_line  = VEC[i].cl;
            cmp_owner = VEC[i].co;
            inv_valid = VEC[i].iv;
            inv_line  = VEC[i].il;
            #1;
            check($sformatf("R1 v%0d outputs", i),
                  32'({issue, sc_fail, seq_error, reset_atomics, flag_set, flag_clr}),
                  32'(VEC[i].ex));
            check($sformatf("R9 v%0d fail_code", i), 32'(fail_code),
                  VEC[i].ex[4] ? 32'h0000_00FE : 32'h0);
            if (VEC[i].ex[1] || VEC[i].ex[0])
                check($sformatf("R11 v%0d flag_line", i), 32'(flag_line), 32'(VEC[i].cl));
            check($sformatf("R12 v%0d sticky", i), 32'(err_sticky), 32'(seen_err));
            if (VEC[i].ex[3]) seen_err = 1'b1;
        end

        // R12: sticky persists through quiet cycles, cleared only by reset
        @(negedge clk);
        idle_inputs();
        repeat (3) @(negedge clk);
        check("R12 sticky held", 32'(err_sticky), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R12 sticky reset", 32'(err_sticky), 0);

        // R8: reset drops the reservation
        @(negedge clk);
        cmp_valid = 1'b1; cmp_kind = KLL; cmp_line = 4'd12; cmp_owner = 2'd2;
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        req_valid = 1'b1; req_kind = KSC; req_line = 4'd12; req_owner = 2'd2;
        #1;
        check("R8 reservation reset", 32'(sc_fail), 1);
        @(negedge clk);
        idle_inputs();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule